// File: doc/BRIEF.md
# Dual-Rail Serial Line Encoder with Run Escapes

This block sends a 32-bit packet one bit per clock over a two-wire level-encoded dual-rail line. The two wires are a value wire and a phase wire. For an ordinary bit, exactly one wire changes. The value wire always shows the bit being sent. The phase wire changes only when a bit repeats the previous value.

A symbol in which both wires change is not a legal data symbol, so it is used as an escape. When the packet comes with a usable run descriptor, the encoder sends an escape in place of the run. It then sends the run length as a 5-bit field, sends a second escape, and carries on with the first bit after the run. A receiver that sees the two escapes writes the repeated bit into all positions of the run at once.

The packet and its descriptor are taken with a valid/ready handshake. The descriptor gives the start index and length of a run found by an upstream detector. The encoder checks the descriptor itself and falls back to plain encoding when the run is not usable.

Top module: `ledr_run_encoder`

## Requirements
- R1: For a plain symbol, line_s takes the value of the bit sent. If that value equals line_s before the symbol, line_p toggles; otherwise line_p holds. Exactly one wire changes.
- R2: Both wires toggle in the same cycle only for an escape symbol. A packet sent without compression never shows such a symbol.
- R3: A compressed run is sent as: one escape, then the run length as 5 plain symbols (most significant bit first, each following the R1 rule), then one escape. The next symbol is the bit at index start+length.
- R4: A descriptor is used only if every one of these holds: run_valid is 1, run_start ≥ 8, run_len ≥ 7, run_start+run_len ≤ 32, and every bit in the run equals the packet bit at index run_start−1. Otherwise the whole packet is sent plain, bit 0 first.
- R5: Each packet uses at most one descriptor. The descriptor is sampled in the accepting cycle, and changes to run_valid, run_start or run_len after that have no effect on the packet.
- R6: Reset drives line_s and line_p to 0, pkt_ready to 1 and done to 0. Between packets the wires keep their last levels, and the next packet is encoded relative to those levels.
- R7: A packet is accepted on a rising edge where pkt_valid and pkt_ready are both 1. Its first symbol appears on the next edge, and one symbol follows per cycle. pkt_ready stays 0 from acceptance until the last symbol.
- R8: done is a one-cycle pulse that comes with the last symbol of the packet, and pkt_ready is 1 in that same cycle. This also holds when that last symbol is the closing escape of a run that ends at bit 31.
- R9: While no packet is in flight and none is being accepted, line_s and line_p hold their levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one symbol per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_valid | input | 1 | Packet and descriptor offered |
| pkt_ready | output | 1 | Encoder idle, can accept |
| pkt_data | input | 32 | Packet bits, bit 0 sent first |
| run_valid | input | 1 | Descriptor present |
| run_start | input | 5 | Index of first bit of run |
| run_len | input | 6 | Number of bits in run |
| line_s | output | 1 | Value wire |
| line_p | output | 1 | Phase wire |
| done | output | 1 | Pulse with last symbol of packet |

## Verification
Some rules are checked by assertions on every cycle. These are: the one-wire rule for plain symbols (R1), escapes appearing only in packets that were cleared for compression (R2), the wires holding still while idle (R9), and the handshake and done relation (R7, R8). Other behaviour only shows up in the bench scenarios: the exact symbol order of an escaped run, the length bits, where sending resumes after the run, and descriptor rejection. The bench checks these by tracking the wire levels symbol by symbol against its own model of each packet. Those scenarios include runs of ones and of zeros, a run of exactly the minimum length, a run that reaches bit 31, every rejection cause, and descriptor changes after acceptance.

// File: rtl/ledr_run_encoder.sv
module ledr_run_encoder #(
  parameter int W      = 32,
  parameter int PLAIN  = 8,
  parameter int MINRUN = 7,
  parameter int LW     = 5,
  localparam int IW    = $clog2(W),
  localparam int CW    = $clog2(LW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pkt_valid,
  output logic          pkt_ready,
  input  logic [W-1:0]  pkt_data,
  input  logic          run_valid,
  input  logic [IW-1:0] run_start,
  input  logic [IW:0]   run_len,
  output logic          line_s,
  output logic          line_p,
  output logic          done
);

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_LEN, S_MEND} st_t;

  st_t           st;
  logic [W-1:0]  data_q;
  logic          comp_q;
  logic [IW-1:0] rs_q;
  logic [IW:0]   rl_q;
  logic [IW-1:0] ptr;
  logic [CW-1:0] cnt;

  logic [IW:0] in_end;
  logic        ref_bit;
  logic        mismatch;
  logic        usable;

  assign in_end  = {1'b0, run_start} + run_len;
  assign ref_bit = (run_start == '0) ? 1'b0 : pkt_data[run_start - IW'(1)];

  always_comb begin
    mismatch = 1'b0;
    for (int i = 0; i < W; i++) begin
      if ((IW'(i) >= run_start) && ((IW+1)'(i) < in_end) && (pkt_data[i] != ref_bit))
        mismatch = 1'b1;
    end
  end

  assign usable = run_valid
               && (run_start >= IW'(PLAIN))
               && (run_len >= (IW+1)'(MINRUN))
               && (run_len < (IW+1)'(1 << LW))
               && (in_end <= (IW+1)'(W))
               && !mismatch;

  logic [IW:0] run_end;
  logic        at_run;
  logic        emit_plain;
  logic        plain_bit;
  logic        len_bit;

  assign run_end    = {1'b0, rs_q} + rl_q;
  assign at_run     = comp_q && (ptr == rs_q);
  assign emit_plain = (st == S_DATA) && !at_run;
  assign plain_bit  = data_q[ptr];
  assign len_bit    = rl_q[cnt];
  assign pkt_ready  = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      data_q <= '0;
      comp_q <= 1'b0;
      rs_q   <= '0;
      rl_q   <= '0;
      ptr    <= '0;
      cnt    <= '0;
      line_s <= 1'b0;
      line_p <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (pkt_valid) begin
            data_q <= pkt_data;
            comp_q <= usable;
            rs_q   <= run_start;
            rl_q   <= run_len;
            ptr    <= '0;
            st     <= S_DATA;
          end
        end
        S_DATA: begin
          if (at_run) begin
            line_s <= ~line_s;
            line_p <= ~line_p;
            cnt    <= CW'(LW - 1);
            st     <= S_LEN;
          end else begin
            line_s <= plain_bit;
            if (plain_bit == line_s) line_p <= ~line_p;
            if (ptr == IW'(W - 1)) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              ptr <= ptr + IW'(1);
            end
          end
        end
        S_LEN: begin
          line_s <= len_bit;
          if (len_bit == line_s) line_p <= ~line_p;
          if (cnt == '0) st <= S_MEND;
          else cnt <= cnt - CW'(1);
        end
        S_MEND: begin
          line_s <= ~line_s;
          line_p <= ~line_p;
          ptr    <= run_end[IW-1:0];
          if (run_end == (IW+1)'(W)) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            st <= S_DATA;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ledr_run_encoder_chk.sv
module ledr_run_encoder_chk (
  input logic clk,
  input logic rst_n,
  input logic pkt_valid,
  input logic pkt_ready,
  input logic line_s,
  input logic line_p,
  input logic done,
  input logic comp_q,
  input logic emit_plain,
  input logic plain_bit
);

  assert_plain_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
    emit_plain |=> line_s == $past(plain_bit));

  assert_plain_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
    emit_plain |=> line_p == (($past(line_s) == $past(plain_bit)) ? ~$past(line_p) : $past(line_p)));

  assert_escape_only_comp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((line_s != $past(line_s)) && (line_p != $past(line_p))) |-> $past(comp_q));

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_ready) |=> !pkt_ready);

  assert_symbol_each_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_ready |=> ((line_s != $past(line_s)) || (line_p != $past(line_p))));

  assert_done_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pkt_ready);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_ready && !pkt_valid) |=> ($stable(line_s) && $stable(line_p)));

endmodule

bind ledr_run_encoder ledr_run_encoder_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .pkt_valid(pkt_valid),
  .pkt_ready(pkt_ready),
  .line_s(line_s),
  .line_p(line_p),
  .done(done),
  .comp_q(comp_q),
  .emit_plain(emit_plain),
  .plain_bit(plain_bit)
);

// File: tb/ledr_run_encoder_tb.sv
`timescale 1ns/1ps
module ledr_run_encoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_valid = 1'b0;
  logic        pkt_ready;
  logic [31:0] pkt_data = '0;
  logic        run_valid = 1'b0;
  logic [4:0]  run_start = '0;
  logic [5:0]  run_len = '0;
  logic        line_s, line_p, done;

  int total = 0;
  int bad = 0;
  logic ms = 1'b0;
  logic mp = 1'b0;

  always #2 clk = ~clk;

  ledr_run_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_data(pkt_data), .run_valid(run_valid), .run_start(run_start),
    .run_len(run_len), .line_s(line_s), .line_p(line_p), .done(done)
  );

  // {data, run_valid, run_start, run_len}
  localparam int NV = 11;
  localparam logic [43:0] VEC [NV] = '{
    {32'hA5A5_5A5A, 1'b0, 5'd0,  6'd0},   // plain R1
    {32'h001F_FF80, 1'b1, 5'd8,  6'd13},  // ones run R3
    {32'hFFFF_FF80, 1'b1, 5'd8,  6'd24},  // run to bit 31 R8
    {32'h0000_3F80, 1'b1, 5'd8,  6'd6},   // too short R4
    {32'hFFFF_FF80, 1'b1, 5'd7,  6'd10},  // start in plain zone R4
    {32'hFFFF_FF00, 1'b1, 5'd8,  6'd10},  // differs from bit 7 R4
    {32'h001F_FF80, 1'b0, 5'd8,  6'd13},  // descriptor absent R4
    {32'hFFF0_0055, 1'b1, 5'd8,  6'd12},  // zeros run R3
    {32'h001F_FF80, 1'b1, 5'd8,  6'd20},  // mismatch inside R4
    {32'h0000_7F80, 1'b1, 5'd8,  6'd7},   // minimum length R4
    {32'h8000_0000, 1'b1, 5'd12, 6'd24}   // overruns end R4
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit eligible(input logic [31:0] d, input bit rv,
                                  input int st, input int ln);
    bit rb;
    if (!rv || st < 8 || ln < 7 || ln > 31 || st + ln > 32) return 0;
    rb = d[st-1];
    for (int i = st; i < st + ln; i++) if (d[i] != rb) return 0;
    return 1;
  endfunction

  task automatic emit(input bit esc, input bit b, input bit last, input string req);
    @(posedge clk);
    @(negedge clk);
    if (esc) begin
      ms = ~ms;
      mp = ~mp;
    end else begin
      if (b == ms) mp = ~mp;
      ms = b;
    end
    chk(line_s == ms, req, line_s, ms);
    chk(line_p == mp, req, line_p, mp);
    chk(done == last, "R8", done, last);
    chk(pkt_ready == last, "R7", pkt_ready, last);
  endtask

  task automatic send(input logic [31:0] d, input bit rv, input int st,
                      input int ln, input bit disturb);
    bit el;
    int nsym, k, p;
    el = eligible(d, rv, st, ln);
    nsym = el ? (st + 7 + (32 - st - ln)) : 32;
    @(negedge clk);
    pkt_data  = d;
    run_valid = rv;
    run_start = 5'(st);
    run_len   = 6'(ln);
    pkt_valid = 1'b1;
    chk(pkt_ready == 1'b1, "R7", pkt_ready, 1);
    @(posedge clk);
    @(negedge clk);
    pkt_valid = 1'b0;
    if (disturb) begin
      run_valid = ~rv;
      run_start = 5'd9;
      run_len   = 6'd8;
      pkt_data  = ~d;
    end
    chk(pkt_ready == 1'b0, "R7", pkt_ready, 0);
    k = 0;
    p = 0;
    while (p < 32) begin
      if (el && p == st) begin
        k++; emit(1'b1, 1'b0, k == nsym, "R3");
        for (int j = 4; j >= 0; j--) begin
          k++; emit(1'b0, ln[j], k == nsym, "R3");
        end
        k++; emit(1'b1, 1'b0, k == nsym, "R3");
        p = st + ln;
      end else begin
        k++; emit(1'b0, d[p], k == nsym, el ? "R3" : "R1");
        p++;
      end
    end
  endtask

  initial begin
    #(4ns * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(line_s == 1'b0, "R6", line_s, 0);
    chk(line_p == 1'b0, "R6", line_p, 0);
    chk(pkt_ready == 1'b1, "R6", pkt_ready, 1);
    chk(done == 1'b0, "R6", done, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      send(VEC[v][43:12], VEC[v][11], int'(VEC[v][10:6]), int'(VEC[v][5:0]), 1'b0);
    end

    // R5: descriptor and data changed after acceptance are ignored
    send(32'h001F_FF80, 1'b1, 8, 13, 1'b1);
    send(32'h0000_3F80, 1'b1, 8, 6, 1'b1);

    // R9: wires hold while idle
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(line_s == ms, "R9", line_s, ms);
    chk(line_p == mp, "R9", line_p, mp);

    // R6: phase continues into the next packet from the held levels
    send(32'hFFFF_FFFF, 1'b0, 0, 0, 1'b0);

    // R6: reset in flight returns the idle state
    @(negedge clk);
    pkt_data  = 32'h1234_5678;
    run_valid = 1'b0;
    pkt_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pkt_valid = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(line_s == 1'b0, "R6", line_s, 0);
    chk(line_p == 1'b0, "R6", line_p, 0);
    chk(pkt_ready == 1'b1, "R6", pkt_ready, 1);
    chk(done == 1'b0, "R6", done, 0);
    ms = 1'b0;
    mp = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    send(32'hFFF0_0055, 1'b1, 8, 12, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule